// File: doc/BRIEF.md
# Configurable External Interrupt Detector

This block watches two external interrupt lines and turns activity on each line into a request for a nested interrupt controller. Each channel has its own four-bit configuration nibble. The nibble holds a trigger mode and an enable bit. The trigger mode can be rising edge, falling edge, either edge, high level or low level. Each channel also has an input-path enable, which gates the pad before anything else sees it. A channel reports nothing while its path is closed.

Pad values are brought into the core clock domain through a two-flop synchroniser. Edge triggers give a one-cycle request pulse. Level triggers hold the request for as long as the level lasts. A wake output is the OR of all requests, so any reported event can bring the device out of a low-power state. The configuration is presented on direct ports. An outer wrapper with a register bus drives those ports.

Top module: `ext_irq_detect`

## Requirements
- R1: While reset is asserted, and after it is released with no stimulus, every request output and the wake output are low.
- R2: Mode code 0 (rising edge) gives a request exactly one cycle wide. The request appears three clock edges after the pad goes from low to high. A high-to-low change gives nothing.
- R3: Mode code 1 (falling edge) gives a one-cycle request three edges after the pad goes from high to low. A low-to-high change gives nothing.
- R4: Mode code 2 (either edge) gives a one-cycle request for each change of the pad, in both directions.
- R5: Mode code 3 (high level) asserts the request three edges after the pad goes high. The request stays asserted while the pad is high and drops three edges after the pad goes low.
- R6: Mode code 4 (low level) asserts the request while the pad is low. A low level lasting one core clock cycle gives a request exactly one cycle wide.
- R7: Channel k's configuration sits in bits 4k+3 down to 4k of the configuration word. The mode is in the lower three bits and the enable is in the top bit, so channel 1's enable is bit 7. With the enable clear, or with mode codes 5 to 7, the channel never raises a request.
- R8: While a channel's input-path enable is low, its request is low from the next cycle on, whatever the pad does.
- R9: The wake output is high in exactly the cycles in which at least one request output is high.
- R10: An edge that reaches the detector in the same cycle as a change of that channel's configuration is not reported. Later edges are reported as normal.
- R11: The two channels are independent. Simultaneous events on both channels each produce their own request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pad_i | input | NUM_CH | Raw external interrupt lines, one per channel |
| path_en_i | input | NUM_CH | Per-channel input-path enable; gates the pad before detection |
| cfg_i | input | 4*NUM_CH | Per-channel nibble: bit 3 enable, bits 2:0 trigger mode |
| irq_o | output | NUM_CH | Per-channel interrupt request to the interrupt controller |
| wake_o | output | 1 | OR of all requests, used to leave a low-power state |

## Verification
The bench turns a channel on while an edge is already travelling through the synchroniser. A design that does not reload its edge history on a configuration change would fire a stray pulse there. It drives a low level lasting a single cycle in low-level mode. A detector that filters or stretches levels would either miss that level or widen the request. It closes the input path while a high level is being reported, and toggles a pad on a disabled channel and on one using an unused mode code. A design with a gating mistake would let requests or wake leak through in those cases. It also fires both channels in the same cycle with opposite polarities, which exposes any shared or swapped per-channel state.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int CFG_W  = 4;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    TRIG_RISE = 3'd0,
    TRIG_FALL = 3'd1,
    TRIG_BOTH = 3'd2,
    TRIG_HIGH = 3'd3,
    TRIG_LOW  = 3'd4
  } trig_e;

  typedef struct packed {
    logic              en;
    logic [MODE_W-1:0] mode;
  } chan_cfg_t;

endpackage

// File: rtl/ext_irq_rst_sync.sv
module ext_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] st_q;
  logic [STAGES-1:0][WIDTH-1:0] st_d;

  always_comb begin
    st_d[0] = d_i;
    for (int k = 1; k < STAGES; k++) begin
      st_d[k] = st_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
  import ext_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl_i,      // synchronised, gated pad value
  input  logic      path_s_i,   // synchronised path enable
  input  logic      path_en_i,  // live path enable
  input  chan_cfg_t cfg_i,
  output logic      irq_o
);

  logic      prev_q, prev_d;
  logic      path_q, path_d;
  chan_cfg_t cfg_q, cfg_d;
  logic      irq_q, irq_d;

  logic cfg_chg;
  logic rise, fall;
  logic edge_hit, lvl_hit;
  logic path_ok;

  always_comb begin
    cfg_chg  = (cfg_i != cfg_q) || (path_s_i != path_q);
    rise     = lvl_i & ~prev_q;
    fall     = ~lvl_i & prev_q;
    edge_hit = 1'b0;
    lvl_hit  = 1'b0;
    case (cfg_i.mode)
      TRIG_RISE: edge_hit = rise;
      TRIG_FALL: edge_hit = fall;
      TRIG_BOTH: edge_hit = rise | fall;
      TRIG_HIGH: lvl_hit  = lvl_i;
      TRIG_LOW:  lvl_hit  = ~lvl_i;
      default:   begin edge_hit = 1'b0; lvl_hit = 1'b0; end
    endcase
    path_ok = path_en_i & path_s_i;
    irq_d   = cfg_i.en & path_ok & ((edge_hit & ~cfg_chg) | lvl_hit);
    // history reloads every cycle, including the cycle of a config change
    prev_d  = lvl_i;
    path_d  = path_s_i;
    cfg_d   = cfg_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      path_q <= 1'b0;
      cfg_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      path_q <= path_d;
      cfg_q  <= cfg_d;
      irq_q  <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       pad_i,
  input  logic [NUM_CH-1:0]       path_en_i,
  input  logic [CFG_W*NUM_CH-1:0] cfg_i,
  output logic [NUM_CH-1:0]       irq_o,
  output logic                    wake_o
);

  localparam int SYNC_W = 2 * NUM_CH;

  logic              rst_core_n;
  logic [NUM_CH-1:0] gated;
  logic [SYNC_W-1:0] sync_q;

  ext_irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_ni (rst_n),
    .rst_no  (rst_core_n)
  );

  assign gated = pad_i & path_en_i;

  ext_irq_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   ({path_en_i, gated}),
    .q_o   (sync_q)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    chan_cfg_t cfg_g;
    assign cfg_g = chan_cfg_t'(cfg_i[CFG_W*g +: CFG_W]);

    ext_irq_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .lvl_i     (sync_q[g]),
      .path_s_i  (sync_q[NUM_CH+g]),
      .path_en_i (path_en_i[g]),
      .cfg_i     (cfg_g),
      .irq_o     (irq_o[g])
    );
  end

  assign wake_o = |irq_o;

endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk
  import ext_irq_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH-1:0]       pad_i,
  input logic [NUM_CH-1:0]       path_en_i,
  input logic [CFG_W*NUM_CH-1:0] cfg_i,
  input logic [NUM_CH-1:0]       irq_o,
  input logic                    wake_o
);

  localparam logic [CFG_W-1:0] RISE_ON = {1'b1, TRIG_RISE};
  localparam logic [CFG_W-1:0] HIGH_ON = {1'b1, TRIG_HIGH};

  logic [2:0] alive_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               alive_q <= '0;
    else if (alive_q != 3'd7) alive_q <= alive_q + 3'd1;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    logic [CFG_W-1:0] nib;
    assign nib = cfg_i[CFG_W*g +: CFG_W];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (alive_q == 3'd7 && $past(nib) == RISE_ON && $past(nib, 2) == RISE_ON
       && $past(irq_o[g])) |-> !irq_o[g]); // R2

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (alive_q == 3'd7 && $past(nib) == HIGH_ON && $past(path_en_i[g])
       && $past(path_en_i[g], 3) && $past(pad_i[g], 3)) |-> irq_o[g]); // R5

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!nib[CFG_W-1] || nib[CFG_W-2:0] > 3'd4) |=> !irq_o[g]); // R7

    AST_PATH_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      !path_en_i[g] |=> !irq_o[g]); // R8
  end

  AST_WAKE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_o) |-> $past(|path_en_i)); // R9

endmodule

bind ext_irq_detect ext_irq_detect_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pad_i     (pad_i),
  .path_en_i (path_en_i),
  .cfg_i     (cfg_i),
  .irq_o     (irq_o),
  .wake_o    (wake_o)
);

// File: tb/ext_irq_detect_tb.sv
`timescale 1ns/1ps
module ext_irq_detect_tb;
  import ext_irq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] NB_OFF = 4'b0000;

  logic       clk;
  logic       rst_n;
  logic [1:0] pad;
  logic [1:0] pen;
  logic [7:0] cfg;
  logic [1:0] irq_o;
  logic       wake_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int c;

  typedef struct {
    int    when;
    int    ch;   // 0,1 = request line, 2 = wake
    logic  val;
    string req;
  } exp_t;

  exp_t sb[$];

  ext_irq_detect u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_i     (pad),
    .path_en_i (pen),
    .cfg_i     (cfg),
    .irq_o     (irq_o),
    .wake_o    (wake_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] nib(logic en, logic [2:0] m);
    return {en, m};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(int when, int ch, logic val, string req);
    exp_t e;
    e.when = when; e.ch = ch; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  task automatic expect_span(int from, int to, int ch, logic val, string req);
    for (int t = from; t <= to; t++) expect_at(t, ch, val, req);
  endtask

  task automatic check_now(logic act, logic exp, string req, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  // monitor: pops due items from the scoreboard a quarter period after each edge
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #(CLK_PERIOD/4);
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].when == cyc) begin
          logic act;
          act = (sb[i].ch == 2) ? wake_o : irq_o[sb[i].ch];
          n_cmp++;
          if (act !== sb[i].val) begin
            n_bad++;
            $display("FAIL %s ch%0d cycle %0d: got %0b expected %0b",
                     sb[i].req, sb[i].ch, cyc, act, sb[i].val);
          end
          sb.delete(i);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    pad = '0; pen = '0; cfg = '0; rst_n = 1'b0;
    tick(4);
    check_now(irq_o[0], 1'b0, "R1", "irq0 in reset");
    check_now(irq_o[1], 1'b0, "R1", "irq1 in reset");
    check_now(wake_o,   1'b0, "R1", "wake in reset");
    rst_n = 1'b1;
    tick(6);
    check_now(|irq_o, 1'b0, "R1", "irq after reset");
    check_now(wake_o, 1'b0, "R1", "wake after reset");

    // R2 rising edge
    pen = 2'b11; cfg = {NB_OFF, nib(1'b1, TRIG_RISE)};
    tick(5);
    pad[0] = 1'b1; c = cyc;
    expect_at(c+2, 0, 1'b0, "R2"); expect_at(c+3, 0, 1'b1, "R2");
    expect_at(c+4, 0, 1'b0, "R2");
    expect_at(c+3, 2, 1'b1, "R9"); expect_at(c+4, 2, 1'b0, "R9");
    tick(6);
    pad[0] = 1'b0; c = cyc;
    expect_span(c+1, c+6, 0, 1'b0, "R2");
    tick(7);

    // R3 falling edge
    cfg = {NB_OFF, nib(1'b1, TRIG_FALL)};
    tick(5);
    pad[0] = 1'b1; c = cyc;
    expect_span(c+1, c+6, 0, 1'b0, "R3");
    tick(6);
    pad[0] = 1'b0; c = cyc;
    expect_at(c+2, 0, 1'b0, "R3"); expect_at(c+3, 0, 1'b1, "R3");
    expect_at(c+4, 0, 1'b0, "R3");
    tick(6);

    // R4 both edges
    cfg = {NB_OFF, nib(1'b1, TRIG_BOTH)};
    tick(5);
    pad[0] = 1'b1; c = cyc;
    expect_at(c+3, 0, 1'b1, "R4"); expect_at(c+4, 0, 1'b0, "R4");
    tick(6);
    pad[0] = 1'b0; c = cyc;
    expect_at(c+3, 0, 1'b1, "R4"); expect_at(c+4, 0, 1'b0, "R4");
    tick(6);

    // R5 high level
    cfg = {NB_OFF, nib(1'b1, TRIG_HIGH)};
    tick(5);
    pad[0] = 1'b1; c = cyc;
    expect_at(c+2, 0, 1'b0, "R5");
    expect_span(c+3, c+7, 0, 1'b1, "R5");
    expect_at(c+8, 0, 1'b0, "R5");
    expect_at(c+3, 2, 1'b1, "R9");
    tick(5);
    pad[0] = 1'b0;
    tick(8);

    // R6 low level, including a one-cycle low
    pad[0] = 1'b1;
    tick(5);
    cfg = {NB_OFF, nib(1'b1, TRIG_LOW)}; c = cyc;
    expect_span(c+1, c+4, 0, 1'b0, "R6");
    tick(5);
    pad[0] = 1'b0; c = cyc;
    expect_at(c+2, 0, 1'b0, "R6"); expect_at(c+3, 0, 1'b1, "R6");
    expect_at(c+4, 0, 1'b0, "R6");
    tick(1);
    pad[0] = 1'b1;
    tick(6);
    pad[0] = 1'b0; c = cyc;
    expect_span(c+3, c+6, 0, 1'b1, "R6");
    expect_at(c+7, 0, 1'b0, "R6");
    tick(4);
    pad[0] = 1'b1;
    tick(6);

    // R8 path closed while a high level is reported, then toggling
    cfg = {NB_OFF, nib(1'b1, TRIG_HIGH)};
    tick(5);
    pen[0] = 1'b0; c = cyc;
    expect_span(c+1, c+10, 0, 1'b0, "R8");
    expect_at(c+1, 2, 1'b0, "R8");
    tick(1);
    cfg = {NB_OFF, nib(1'b1, TRIG_RISE)};
    pad[0] = 1'b0; tick(2);
    pad[0] = 1'b1; tick(2);
    pad[0] = 1'b0; tick(6);
    pen[0] = 1'b1;
    tick(6);

    // R7 enable clear, then unused mode codes
    cfg = {NB_OFF, nib(1'b0, TRIG_RISE)};
    tick(5);
    pad[0] = 1'b1; c = cyc;
    expect_span(c+1, c+6, 0, 1'b0, "R7");
    tick(6);
    pad[0] = 1'b0;
    tick(3);
    cfg = {NB_OFF, nib(1'b1, 3'd5)};
    tick(3);
    pad[0] = 1'b1; c = cyc;
    expect_span(c+1, c+6, 0, 1'b0, "R7");
    tick(6);
    cfg = {NB_OFF, nib(1'b1, 3'd7)}; c = cyc;
    expect_span(c+1, c+6, 0, 1'b0, "R7");
    tick(3);
    pad[0] = 1'b0;
    tick(6);

    // R10 channel enabled while an edge is in flight
    cfg = {NB_OFF, nib(1'b0, TRIG_RISE)};
    tick(5);
    pad[0] = 1'b1; c = cyc;
    expect_span(c+3, c+7, 0, 1'b0, "R10");
    tick(2);
    cfg = {NB_OFF, nib(1'b1, TRIG_RISE)};
    tick(7);
    pad[0] = 1'b0;
    tick(5);
    pad[0] = 1'b1; c = cyc;
    expect_at(c+3, 0, 1'b1, "R10"); expect_at(c+4, 0, 1'b0, "R10");
    tick(6);

    // R11 both channels at once, opposite polarities
    pad = 2'b10;
    cfg = {nib(1'b1, TRIG_FALL), nib(1'b1, TRIG_RISE)};
    tick(6);
    pad = 2'b01; c = cyc;
    expect_at(c+3, 0, 1'b1, "R11"); expect_at(c+3, 1, 1'b1, "R11");
    expect_at(c+4, 0, 1'b0, "R11"); expect_at(c+4, 1, 1'b0, "R11");
    expect_at(c+3, 2, 1'b1, "R9");
    tick(6);
    pad = 2'b10; c = cyc;
    expect_span(c+1, c+6, 0, 1'b0, "R11");
    expect_span(c+1, c+6, 1, 1'b0, "R11");
    expect_span(c+1, c+6, 2, 1'b0, "R9");
    tick(8);

    if (sb.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule